// File: doc/BRIEF.md
# PHY Management Register Responder

This block lets software reach the registers of one PHY through a small memory-mapped command unit. Software first loads a write-data register, then writes a command word that names a PHY address, a register index and an operation, with an initiate flag. When the command fires, the unit writes the PHY register from the write-data register, or fetches the PHY register into a read-data register that software then reads back. No serial management signalling is modelled. The access takes effect at the clock edge that accepts the command.

The PHY is a behavioural register file at one address, set by a parameter. Most indices hold what was last written. A few are computed on every read: the basic status word follows the link state, the link-partner word mirrors the advertised abilities, a diagnostic word reports speed and duplex derived from the advertisement, and one vendor word is a constant. Any write to the PHY clears the self-resetting bit of the control register.

The register bus is a simple valid/ready port that is always ready. A read returns its data one cycle after the request.

Top module: `mgmt_phy_responder`

## Requirements
- R1: The command word (bus offset 0) carries the PHY address in bits 28:24, the register index in bits 20:16, the operation in bits 15:14 and the initiate flag in bit 11. Other bits have no effect on the access.
- R2: An initiated command with operation 1 and a matching PHY address writes bits 15:0 of the write-data register (bus offset 1) into the selected PHY register.
- R3: An initiated command with operation 2 and a matching PHY address loads the PHY register value into the read-data register (bus offset 2, bits 15:0, upper bits zero). The new value is readable starting the cycle after the command.
- R4: Operations 0 and 3, and any command with the initiate flag clear, neither change a PHY register nor the read-data register.
- R5: A read to a PHY address other than the configured one (default 7) loads 0xFFFF. A write to such an address changes nothing.
- R6: Reading the command register returns the last command word with bit 7 forced to 1.
- R7: PHY register 1 reads 0x782E while link_up is high and 0x0000 while it is low.
- R8: PHY register 5 reads 0x4001 ORed with bits 8:5 of PHY register 4.
- R9: PHY register 18 reads 0 while link is down. Otherwise bit 10 = reg4[7] | reg4[8] and bit 11 = reg4[8] | reg4[6], all other bits 0.
- R10: PHY register 17 always reads 0x8000.
- R11: After any PHY register write, bit 15 of PHY register 0 is 0, including when that write targets register 0 with bit 15 set.
- R12: After reset, PHY registers 0, 2, 3 and 4 hold 0x3100, 0x0300, 0xE400 and 0x01E1.
- R13: req_ready is always 1. A bus read gives rsp_valid high with data in the following cycle only. Offsets other than 0, 1 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state seen by the PHY model |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always ready |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench goes after the computed PHY registers under several advertisement patterns and under link loss. A design that stored these registers instead of computing them would return stale or written values. The bench also writes register 0 with its reset bit set, which shows whether the bit clears after the store rather than before it. It issues commands to an absent PHY address, with illegal operations and with the initiate flag clear, and reads back both the target register and the read-data register. A decoder that took the wrong field bits or ignored the initiate flag would corrupt one of them. A command word with stray bits set outside the fields shows whether the decode is too wide.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int CMD_PHY_LSB  = 24;
  localparam int CMD_REG_LSB  = 16;
  localparam int CMD_OP_LSB   = 14;
  localparam int CMD_INIT_BIT = 11;
  localparam int CMD_RDY_BIT  = 7;

  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam int OFS_CMD   = 0;
  localparam int OFS_WDATA = 1;
  localparam int OFS_RDATA = 2;

  localparam logic [15:0] ABSENT_WORD = 16'hFFFF;
  localparam logic [15:0] VENDOR_WORD = 16'h8000;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [1:0] op;
    logic       init;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t unpack_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.phy  = w[CMD_PHY_LSB +: 5];
    c.regn = w[CMD_REG_LSB +: 5];
    c.op   = w[CMD_OP_LSB +: 2];
    c.init = w[CMD_INIT_BIT];
    return c;
  endfunction

  function automatic logic [15:0] reset_word(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] status_word(input logic link);
    return link ? 16'h782E : 16'h0000;
  endfunction

  function automatic logic [15:0] partner_word(input logic [15:0] adv);
    return 16'h4001 | (adv & 16'h01E0);
  endfunction

  function automatic logic [15:0] diag_word(input logic link, input logic [15:0] adv);
    logic [15:0] d;
    d = '0;
    if (link) begin
      d[10] = adv[7] | adv[8];
      d[11] = adv[8] | adv[6];
    end
    return d;
  endfunction
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
  import mgmt_phy_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  output logic        fire,
  output logic [1:0]  op,
  output logic [4:0]  regn,
  output logic        hit,
  output logic        do_write,
  output logic        do_read
);
  mgmt_cmd_t c;

  always_comb begin
    c        = unpack_cmd(cmd_word);
    fire     = cmd_wr & c.init;
    op       = c.op;
    regn     = c.regn;
    hit      = (c.phy == 5'(PHY_ADDR));
    do_write = fire && (c.op == OP_WRITE);
    do_read  = fire && (c.op == OP_READ);
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import mgmt_phy_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int REG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_up,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [$clog2(NREGS)-1:0] rd_idx,
  output logic [REG_W-1:0]         rd_data,
  output logic [REG_W-1:0]         ctrl_reg
);
  localparam int IDX_W = $clog2(NREGS);

  logic [REG_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (!rst_n) begin
        mem[i] <= reset_word(i);
      end else if (wr_en) begin
        logic [REG_W-1:0] nxt;
        nxt = mem[i];
        if (wr_idx == IDX_W'(i)) nxt = wr_data;
        if (i == 0) nxt[15] = 1'b0;
        mem[i] <= nxt;
      end
    end
  end

  always_comb begin
    if (rd_idx == IDX_W'(1))       rd_data = status_word(link_up);
    else if (rd_idx == IDX_W'(5))  rd_data = partner_word(mem[4]);
    else if (rd_idx == IDX_W'(17)) rd_data = VENDOR_WORD;
    else if (rd_idx == IDX_W'(18)) rd_data = diag_word(link_up, mem[4]);
    else                           rd_data = mem[rd_idx];
  end

  assign ctrl_reg = mem[0];
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_phy_pkg::*;
#(
  parameter int PHY_ADDR = 7,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int NREGS = 32;
  localparam int IDX_W = $clog2(NREGS);

  logic [31:0] cmd_q;
  logic [15:0] wdata_q;
  logic [15:0] rdata_q;

  logic wr_cmd, wr_wdata, bus_rd;
  assign wr_cmd   = req_valid & req_write & (req_addr == ADDR_W'(OFS_CMD));
  assign wr_wdata = req_valid & req_write & (req_addr == ADDR_W'(OFS_WDATA));
  assign bus_rd   = req_valid & ~req_write;

  logic        cmd_fire, rd_hit, do_wr, phy_rd_evt;
  logic [1:0]  cmd_op;
  logic [4:0]  rd_reg;

  mgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .cmd_wr   (wr_cmd),
    .cmd_word (req_wdata),
    .fire     (cmd_fire),
    .op       (cmd_op),
    .regn     (rd_reg),
    .hit      (rd_hit),
    .do_write (do_wr),
    .do_read  (phy_rd_evt)
  );

  logic phy_wr_evt;
  assign phy_wr_evt = do_wr & rd_hit;

  logic [15:0] phy_rd_data, ctrl_reg;

  phy_regfile #(.NREGS(NREGS), .REG_W(16)) u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .wr_en    (phy_wr_evt),
    .wr_idx   (IDX_W'(rd_reg)),
    .wr_data  (wdata_q),
    .rd_idx   (IDX_W'(rd_reg)),
    .rd_data  (phy_rd_data),
    .ctrl_reg (ctrl_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_cmd)     cmd_q   <= req_wdata;
      if (wr_wdata)   wdata_q <= req_wdata[15:0];
      if (phy_rd_evt) rdata_q <= rd_hit ? phy_rd_data : ABSENT_WORD;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (req_addr)
      ADDR_W'(OFS_CMD):   rd_mux = cmd_q | (32'd1 << CMD_RDY_BIT);
      ADDR_W'(OFS_WDATA): rd_mux = {16'd0, wdata_q};
      ADDR_W'(OFS_RDATA): rd_mux = {16'd0, rdata_q};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_rd;
      if (bus_rd) rsp_rdata <= rd_mux;
    end
  end

  assign req_ready = 1'b1;
endmodule

// File: rtl/mgmt_phy_checker.sv
module mgmt_phy_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              cmd_fire,
  input logic [1:0]        cmd_op,
  input logic              phy_wr_evt,
  input logic              phy_rd_evt,
  input logic              rd_hit,
  input logic [4:0]        rd_reg,
  input logic [15:0]       rdata_q,
  input logic [15:0]       ctrl_reg
);
  a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r13_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r6_cmd_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == '0) |=> rsp_rdata[7]);
  a_r11_ctrl_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_evt |=> !ctrl_reg[15]);
  a_r7_status_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rd_evt && rd_hit && rd_reg == 5'd1 && !link_up) |=> rdata_q == 16'h0000);
  a_r5_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rd_evt && !rd_hit) |=> rdata_q == 16'hFFFF);
  a_r4_other_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op != 2'd1 && cmd_op != 2'd2) |-> (!phy_wr_evt && !phy_rd_evt));
  a_r10_vendor_word: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rd_evt && rd_hit && rd_reg == 5'd17) |=> rdata_q == 16'h8000);
endmodule

bind mgmt_phy_responder mgmt_phy_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_up    (link_up),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .cmd_fire   (cmd_fire),
  .cmd_op     (cmd_op),
  .phy_wr_evt (phy_wr_evt),
  .phy_rd_evt (phy_rd_evt),
  .rd_hit     (rd_hit),
  .rd_reg     (rd_reg),
  .rdata_q    (rdata_q),
  .ctrl_reg   (ctrl_reg)
);

// File: tb/tb_mgmt_phy_responder.sv
module tb_mgmt_phy_responder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        link_up = 1;
  logic        req_valid = 0;
  logic        req_write = 0;
  logic [3:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mgmt_phy_responder dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid;
    d = rsp_rdata;
  endtask

  function automatic logic [31:0] cmd(input int phy, input int rg, input int op, input bit init);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(init) << 11);
  endfunction

  task automatic phy_read(input int phy, input int rg, output logic [15:0] d);
    logic [31:0] r; logic v;
    bus_write(4'd0, cmd(phy, rg, 2, 1));
    bus_read(4'd2, r, v);
    d = r[15:0];
  endtask

  task automatic phy_write(input int phy, input int rg, input logic [15:0] d);
    bus_write(4'd1, {16'd0, d});
    bus_write(4'd0, cmd(phy, rg, 1, 1));
  endtask

  task automatic t_reset;
    logic [15:0] d; logic [31:0] r; logic v;
    check("R13 ready", {31'd0, req_ready}, 32'd1);
    check("R13 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    phy_read(7, 0, d);  check("R12 reg0", {16'd0, d}, 32'h3100);
    phy_read(7, 2, d);  check("R12 reg2", {16'd0, d}, 32'h0300);
    phy_read(7, 3, d);  check("R12 reg3", {16'd0, d}, 32'hE400);
    phy_read(7, 4, d);  check("R12 reg4", {16'd0, d}, 32'h01E1);
    phy_read(7, 1, d);  check("R7 status up", {16'd0, d}, 32'h782E);
    phy_read(7, 5, d);  check("R8 partner", {16'd0, d}, 32'h41E1);
    phy_read(7, 17, d); check("R10 vendor", {16'd0, d}, 32'h8000);
    phy_read(7, 18, d); check("R9 diag default", {16'd0, d}, 32'h0C00);
    bus_read(4'd0, r, v);
    check("R13 rsp_valid", {31'd0, v}, 32'd1);
    check("R6 cmd readback", r, cmd(7, 18, 2, 1) | 32'h80);
    bus_read(4'd9, r, v);
    check("R13 unmapped", r, 32'd0);
  endtask

  task automatic t_adv;
    logic [15:0] d;
    phy_write(7, 4, 16'h0041);
    phy_read(7, 4, d);  check("R2 reg4 write", {16'd0, d}, 32'h0041);
    phy_read(7, 5, d);  check("R8 partner 0041", {16'd0, d}, 32'h4041);
    phy_read(7, 18, d); check("R9 diag 0041", {16'd0, d}, 32'h0800);
    phy_write(7, 4, 16'h0081);
    phy_read(7, 18, d); check("R9 diag 0081", {16'd0, d}, 32'h0400);
    phy_read(7, 5, d);  check("R8 partner 0081", {16'd0, d}, 32'h4081);
    phy_write(7, 4, 16'h0101);
    phy_read(7, 18, d); check("R9 diag 0101", {16'd0, d}, 32'h0C00);
    phy_write(7, 9, 16'hA5A5);
    phy_read(7, 9, d);  check("R2 reg9 write", {16'd0, d}, 32'hA5A5);
  endtask

  task automatic t_ctrl;
    logic [15:0] d;
    phy_write(7, 0, 16'h9200);
    phy_read(7, 0, d); check("R11 reg0 bit15 cleared", {16'd0, d}, 32'h1200);
  endtask

  task automatic t_link;
    logic [15:0] d;
    link_up = 0;
    phy_read(7, 1, d);  check("R7 status down", {16'd0, d}, 32'h0000);
    phy_read(7, 18, d); check("R9 diag down", {16'd0, d}, 32'h0000);
    phy_read(7, 17, d); check("R10 vendor down", {16'd0, d}, 32'h8000);
    link_up = 1;
    phy_read(7, 1, d);  check("R7 status up again", {16'd0, d}, 32'h782E);
  endtask

  task automatic t_absent;
    logic [15:0] d;
    phy_read(3, 2, d);  check("R5 absent read", {16'd0, d}, 32'hFFFF);
    phy_write(15, 9, 16'h0000);
    phy_read(7, 9, d);  check("R5 absent write dropped", {16'd0, d}, 32'hA5A5);
  endtask

  task automatic t_ops;
    logic [15:0] d; logic [31:0] r; logic v;
    phy_read(7, 9, d);
    bus_write(4'd1, 32'h0000_5555);
    bus_write(4'd0, cmd(7, 9, 0, 1));
    bus_write(4'd0, cmd(7, 9, 3, 1));
    bus_write(4'd0, cmd(7, 9, 1, 0));
    bus_write(4'd0, cmd(7, 2, 2, 0));
    bus_read(4'd2, r, v);
    check("R4 read-data untouched", r, 32'h0000_A5A5);
    phy_read(7, 9, d);
    check("R4 reg9 untouched", {16'd0, d}, 32'hA5A5);
    bus_write(4'd0, cmd(7, 3, 2, 1) | 32'h80A0_2000);
    bus_read(4'd2, r, v);
    check("R1 stray bits ignored", r, 32'h0000_E400);
    check("R3 read-data next cycle", {31'd0, v}, 32'd1);
    bus_write(4'd0, cmd(7, 18, 2, 1));
    bus_read(4'd2, r, v);
    check("R1 reg index bit 20", r, 32'h0000_0C00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_adv();
    t_ctrl();
    t_link();
    t_absent();
    t_ops();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule